// File: doc/BRIEF.md
# Saturating Wiper Command Executor

This block owns the volatile position register of one 10-bit digital potentiometer channel. A serial front end collects a 24-bit command frame, counts the clock edges seen while chip select was low, and on the rising edge of chip select hands the block a one-cycle strobe together with the bit count and the already separated command, address and data fields. The block then applies the 4-bit command to the wiper: a direct load, a unit step up or down, or a one-bit shift left or right that moves the setting by roughly 6 dB. Every step saturates at the code range ends.

A strobe that carried no clock edges at all replays the most recent step command, which supports push-button style adjustment from a bare chip-select pulse. An active-low write-protect input freezes the wiper against every frame-driven change. A restore request from the nonvolatile store sequencer still loads its value into the wiper while write-protect is active, so preset and power-on recall keep working. A readback command copies the wiper into a data register for the serial output path.

Top module: `wiper_cmd_exec`

## Requirements
- R1: After reset the wiper code is midscale (512 for 10 bits) and the readback data is 0.
- R2: The wiper and readback data change only in the cycle after a frame strobe or a restore request; with neither, both hold.
- R3: A complete frame (bit count 24) with command 11 loads the 10-bit data field into the wiper.
- R4: Commands 14 and 15 add one to the wiper and hold at 1023.
- R5: Commands 6 and 7 subtract one from the wiper and hold at 0.
- R6: Commands 12 and 13 shift the wiper left by one bit, filling the LSB with 1; when the MSB is already set the result is 1023.
- R7: Commands 4 and 5 shift the wiper right by one bit, so it settles at 0.
- R8: A strobe with bit count 0 repeats the last step command (4 to 7, 12 to 15) taken from a complete frame; a complete frame with any other command cancels the repeat, and with none stored a bare strobe changes nothing.
- R9: While wp_n is low no frame or repeat changes the wiper.
- R10: A restore request loads its code into the wiper on the next cycle whatever wp_n is, and overrides a frame strobe in the same cycle.
- R11: A strobe whose bit count is neither 0 nor 24 is discarded: wiper, readback data and the remembered step command are left as they were.
- R12: Command 10 copies the wiper as it was before that cycle into the readback data one cycle after the strobe, also while wp_n is low; no other command changes the readback data.
- R13: Commands 4, 6, 10, 11, 12 and 14 act only when the address field equals 0; commands 5, 7, 13 and 15 ignore the address; commands 0, 1, 2, 3, 8 and 9 leave the wiper unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_stb | input | 1 | One-cycle strobe at the end of a chip-select period |
| frm_bits | input | 5 | Number of serial clock edges in that period |
| frm_cmd | input | 4 | Command field of the frame |
| frm_addr | input | 4 | Address field of the frame |
| frm_data | input | 10 | Data field of the frame |
| wp_n | input | 1 | Write protect, active low |
| nv_load_vld | input | 1 | Restore request from the store sequencer |
| nv_load_code | input | 10 | Code to restore into the wiper |
| wiper_code | output | 10 | Current wiper position |
| rdbk_data | output | 10 | Data captured by the readback command |

## Verification
Every result of this block is registered once, so a frame strobe, a bare strobe or a restore request driven before a rising edge shows its effect on wiper_code or rdbk_data right after that edge and never earlier or later. The driver presents each stimulus for exactly one cycle and queues the expected wiper and readback pair for that edge, while the monitor pops one entry shortly after each rising edge that follows a push. Idle cycles also push an unchanged pair, so holding behaviour is compared on the same cycle grid as the commands.

// File: rtl/wcx_pkg.sv
package wcx_pkg;

    // Step flavours; the encoding follows command bits {3,1}.
    typedef enum logic [1:0] {
        STP_SHR = 2'b00,
        STP_DEC = 2'b01,
        STP_SHL = 2'b10,
        STP_INC = 2'b11
    } step_e;

    // Coarse operation class of a command.
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_LOAD = 2'b01,
        OP_READ = 2'b10,
        OP_STEP = 2'b11
    } op_e;

    localparam logic [3:0] CMD_LOAD = 4'd11;
    localparam logic [3:0] CMD_READ = 4'd10;

endpackage

// File: rtl/wcx_decode.sv
module wcx_decode
    import wcx_pkg::*;
#(
    parameter int                 ADDR_W    = 4,
    parameter logic [ADDR_W-1:0]  CHAN_ADDR = '0
) (
    input  logic [3:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    output op_e               op,
    output step_e             kind,
    output logic              hit
);

    logic broadcast;

    always_comb begin
        // Step commands have bit 2 set; bit 0 marks the all-channel form.
        broadcast = cmd[2] & cmd[0];
        hit       = broadcast | (addr == CHAN_ADDR);
        kind      = step_e'({cmd[3], cmd[1]});
        if (cmd[2]) begin
            op = OP_STEP;
        end else if (cmd == CMD_LOAD) begin
            op = OP_LOAD;
        end else if (cmd == CMD_READ) begin
            op = OP_READ;
        end else begin
            op = OP_NONE;
        end
    end

endmodule

// File: rtl/wcx_step_alu.sv
module wcx_step_alu
    import wcx_pkg::*;
#(
    parameter int CODE_W   = 10,
    parameter bit SHL_FILL = 1'b1
) (
    input  logic [CODE_W-1:0] code,
    input  step_e             kind,
    output logic [CODE_W-1:0] next_code
);

    localparam logic [CODE_W-1:0] ALL_ONES = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] ALL_ZERO = {CODE_W{1'b0}};

    logic fill_bit;

    generate
        if (SHL_FILL) begin : g_fill_one
            assign fill_bit = 1'b1;
        end else begin : g_fill_zero
            assign fill_bit = 1'b0;
        end
    endgenerate

    logic at_top;
    logic at_bot;

    always_comb begin
        at_top    = (code == ALL_ONES);
        at_bot    = (code == ALL_ZERO);
        next_code = code;
        unique case (kind)
            STP_INC: next_code = at_top ? code : code + 1'b1;
            STP_DEC: next_code = at_bot ? code : code - 1'b1;
            STP_SHL: next_code = code[CODE_W-1] ? ALL_ONES
                                                : {code[CODE_W-2:0], fill_bit};
            STP_SHR: next_code = {1'b0, code[CODE_W-1:1]};
            default: next_code = code;
        endcase
    end

endmodule

// File: rtl/wiper_cmd_exec.sv
module wiper_cmd_exec
    import wcx_pkg::*;
#(
    parameter int                CODE_W     = 10,
    parameter int                ADDR_W     = 4,
    parameter int                FRAME_BITS = 24,
    parameter logic [ADDR_W-1:0] CHAN_ADDR  = '0,
    parameter bit                SHL_FILL   = 1'b1,
    localparam int               CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_stb,
    input  logic [CNT_W-1:0]  frm_bits,
    input  logic [3:0]        frm_cmd,
    input  logic [ADDR_W-1:0] frm_addr,
    input  logic [CODE_W-1:0] frm_data,
    input  logic              wp_n,
    input  logic              nv_load_vld,
    input  logic [CODE_W-1:0] nv_load_code,
    output logic [CODE_W-1:0] wiper_code,
    output logic [CODE_W-1:0] rdbk_data
);

    localparam logic [CODE_W-1:0] MID_CODE  = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0]  BARE_CNT  = '0;

    typedef struct packed {
        logic [CODE_W-1:0] wiper;
        logic [CODE_W-1:0] rdbk;
        logic              rep_vld;
        logic              rep_hit;
        step_e             rep_kind;
    } state_t;

    state_t st_q, st_d;

    op_e               dec_op;
    step_e             dec_kind;
    logic              dec_hit;
    step_e             alu_kind;
    logic [CODE_W-1:0] alu_out;

    logic full_frame;
    logic bare_frame;
    logic do_step;
    logic do_load;
    logic do_read;

    wcx_decode #(
        .ADDR_W    (ADDR_W),
        .CHAN_ADDR (CHAN_ADDR)
    ) u_decode (
        .cmd  (frm_cmd),
        .addr (frm_addr),
        .op   (dec_op),
        .kind (dec_kind),
        .hit  (dec_hit)
    );

    wcx_step_alu #(
        .CODE_W   (CODE_W),
        .SHL_FILL (SHL_FILL)
    ) u_alu (
        .code      (st_q.wiper),
        .kind      (alu_kind),
        .next_code (alu_out)
    );

    always_comb begin
        st_d       = st_q;
        full_frame = frm_stb && (frm_bits == FULL_CNT);
        bare_frame = frm_stb && (frm_bits == BARE_CNT);

        // A live step takes its flavour from the frame, a replay from memory.
        alu_kind = full_frame ? dec_kind : st_q.rep_kind;

        do_step = (full_frame && dec_op == OP_STEP && dec_hit)
               || (bare_frame && st_q.rep_vld && st_q.rep_hit);
        do_load = full_frame && dec_op == OP_LOAD && dec_hit;
        do_read = full_frame && dec_op == OP_READ && dec_hit;

        // Remember or forget the step used by later bare strobes.
        if (full_frame) begin
            if (dec_op == OP_STEP) begin
                st_d.rep_vld  = 1'b1;
                st_d.rep_hit  = dec_hit;
                st_d.rep_kind = dec_kind;
            end else begin
                st_d.rep_vld  = 1'b0;
            end
        end

        // Readback samples the wiper before any change this cycle.
        if (do_read) begin
            st_d.rdbk = st_q.wiper;
        end

        // Restore outranks protection and any frame.
        if (nv_load_vld) begin
            st_d.wiper = nv_load_code;
        end else if (wp_n) begin
            if (do_load) begin
                st_d.wiper = frm_data;
            end else if (do_step) begin
                st_d.wiper = alu_out;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wiper    <= MID_CODE;
            st_q.rdbk     <= '0;
            st_q.rep_vld  <= 1'b0;
            st_q.rep_hit  <= 1'b0;
            st_q.rep_kind <= STP_SHR;
        end else begin
            st_q <= st_d;
        end
    end

    assign wiper_code = st_q.wiper;
    assign rdbk_data  = st_q.rdbk;

endmodule

// File: rtl/wcx_checker.sv
module wcx_checker #(
    parameter int CODE_W     = 10,
    parameter int FRAME_BITS = 24,
    parameter int CNT_W      = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_stb,
    input logic [CNT_W-1:0]  frm_bits,
    input logic [3:0]        frm_cmd,
    input logic              wp_n,
    input logic              nv_load_vld,
    input logic [CODE_W-1:0] nv_load_code,
    input logic [CODE_W-1:0] wiper_code,
    input logic [CODE_W-1:0] rdbk_data
);

    localparam logic [CODE_W-1:0] TOP  = {CODE_W{1'b1}};
    localparam logic [CNT_W-1:0]  FULL = CNT_W'(FRAME_BITS);

    logic full_q;
    assign full_q = frm_stb && (frm_bits == FULL);

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_stb && !nv_load_vld) |=> $stable(wiper_code)); // R2

    AST_RDBK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_stb) |=> $stable(rdbk_data)); // R12

    AST_RESTORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        nv_load_vld |=> (wiper_code == $past(nv_load_code))); // R10

    AST_WP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_stb && !wp_n && !nv_load_vld) |=> $stable(wiper_code)); // R9

    AST_BAD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_stb && frm_bits != FULL && frm_bits != '0 && !nv_load_vld)
        |=> ($stable(wiper_code) && $stable(rdbk_data))); // R11

    AST_INC_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && frm_cmd == 4'd15 && !nv_load_vld && wiper_code == TOP)
        |=> (wiper_code == TOP)); // R4

    AST_DEC_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && frm_cmd == 4'd7 && !nv_load_vld && wiper_code == '0)
        |=> (wiper_code == '0)); // R5

endmodule

bind wiper_cmd_exec wcx_checker #(
    .CODE_W     (CODE_W),
    .FRAME_BITS (FRAME_BITS),
    .CNT_W      (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_stb      (frm_stb),
    .frm_bits     (frm_bits),
    .frm_cmd      (frm_cmd),
    .wp_n         (wp_n),
    .nv_load_vld  (nv_load_vld),
    .nv_load_code (nv_load_code),
    .wiper_code   (wiper_code),
    .rdbk_data    (rdbk_data)
);

// File: tb/sim_wiper_cmd_exec.sv
module sim_wiper_cmd_exec;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_stb = 1'b0;
    logic [4:0] frm_bits = '0;
    logic [3:0] frm_cmd = '0;
    logic [3:0] frm_addr = '0;
    logic [9:0] frm_data = '0;
    logic       wp_n = 1'b1;
    logic       nv_load_vld = 1'b0;
    logic [9:0] nv_load_code = '0;
    logic [9:0] wiper_code;
    logic [9:0] rdbk_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    wiper_cmd_exec u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .frm_stb      (frm_stb),
        .frm_bits     (frm_bits),
        .frm_cmd      (frm_cmd),
        .frm_addr     (frm_addr),
        .frm_data     (frm_data),
        .wp_n         (wp_n),
        .nv_load_vld  (nv_load_vld),
        .nv_load_code (nv_load_code),
        .wiper_code   (wiper_code),
        .rdbk_data    (rdbk_data)
    );

    // Reference state kept from the requirements.
    logic [9:0] m_w  = 10'd512;
    logic [9:0] m_rd = 10'd0;
    logic       m_rv = 1'b0;
    logic       m_rh = 1'b0;
    logic [3:0] m_rc = 4'd0;

    logic [19:0] q_exp[$];
    string       q_tag[$];

    function automatic logic [9:0] apply_step(input logic [9:0] w, input logic [3:0] c);
        case (c)
            4'd14, 4'd15: return (w == 10'h3FF) ? w : w + 10'd1;          // R4
            4'd6,  4'd7:  return (w == 10'h000) ? w : w - 10'd1;          // R5
            4'd12, 4'd13: return w[9] ? 10'h3FF : {w[8:0], 1'b1};         // R6
            default:      return {1'b0, w[9:1]};                          // R7
        endcase
    endfunction

    function automatic bit is_step(input logic [3:0] c);
        return c inside {4'd4, 4'd5, 4'd6, 4'd7, 4'd12, 4'd13, 4'd14, 4'd15};
    endfunction

    function automatic bit targets(input logic [3:0] c, input logic [3:0] a);
        return (c inside {4'd5, 4'd7, 4'd13, 4'd15}) || (a == 4'd0);     // R13
    endfunction

    // Driver: one strobe cycle, expectation pushed for the following edge.
    task automatic send(input logic [4:0] bits, input logic [3:0] c, input logic [3:0] a,
                        input logic [9:0] d, input logic wp, input logic nv,
                        input logic [9:0] nvc, input string tag);
        logic [9:0] nw;
        @(negedge clk);
        frm_stb = 1'b1; frm_bits = bits; frm_cmd = c; frm_addr = a; frm_data = d;
        wp_n = wp; nv_load_vld = nv; nv_load_code = nvc;
        nw = m_w;
        if (bits == 5'd24) begin
            if (c == 4'd10 && targets(c, a)) m_rd = m_w;
            if (wp && c == 4'd11 && targets(c, a)) nw = d;
            if (wp && is_step(c) && targets(c, a)) nw = apply_step(m_w, c);
            if (is_step(c)) begin
                m_rv = 1'b1; m_rh = targets(c, a); m_rc = c;
            end else begin
                m_rv = 1'b0;
            end
        end else if (bits == 5'd0) begin
            if (wp && m_rv && m_rh) nw = apply_step(m_w, m_rc);
        end
        if (nv) nw = nvc;
        m_w = nw;
        q_exp.push_back({m_w, m_rd});
        q_tag.push_back(tag);
        @(negedge clk);
        frm_stb = 1'b0; nv_load_vld = 1'b0; wp_n = 1'b1;
    endtask

    task automatic frame(input logic [3:0] c, input logic [9:0] d, input string tag);
        send(5'd24, c, 4'd0, d, 1'b1, 1'b0, 10'd0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            q_exp.push_back({m_w, m_rd});
            q_tag.push_back(tag);
        end
    endtask

    // Monitor: compares one expectation right after each clock edge.
    always @(posedge clk) begin
        #1;
        if (q_exp.size() > 0) begin
            logic [19:0] e;
            string       t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if ({wiper_code, rdbk_data} !== e) begin
                fails++;
                $display("FAIL %s: wiper=%0d rdbk=%0d expected wiper=%0d rdbk=%0d",
                         t, wiper_code, rdbk_data, e[19:10], e[9:0]);
            end
        end
    end

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (wiper_code !== 10'd512 || rdbk_data !== 10'd0) begin
            fails++;
            $display("FAIL R1: wiper=%0d rdbk=%0d expected wiper=512 rdbk=0", wiper_code, rdbk_data);
        end

        idle(3, "R2");
        frame(4'd11, 10'd1000, "R3");
        frame(4'd11, 10'd1022, "R3");
        frame(4'd14, 10'd0,    "R4");
        frame(4'd15, 10'd5,    "R4");
        send(5'd0, 4'd0, 4'd0, 10'd0, 1'b1, 1'b0, 10'd0, "R8");
        frame(4'd11, 10'd1,    "R3");
        frame(4'd6,  10'd0,    "R5");
        frame(4'd7,  10'd0,    "R5");
        send(5'd0, 4'd0, 4'd0, 10'd0, 1'b1, 1'b0, 10'd0, "R8");
        frame(4'd11, 10'd5,    "R3");
        frame(4'd12, 10'd0,    "R6");
        frame(4'd13, 10'd0,    "R6");
        frame(4'd11, 10'd600,  "R3");
        frame(4'd12, 10'd0,    "R6");
        frame(4'd11, 10'd5,    "R3");
        frame(4'd4,  10'd0,    "R7");
        frame(4'd5,  10'd0,    "R7");
        frame(4'd4,  10'd0,    "R7");
        send(5'd0, 4'd0, 4'd0, 10'd0, 1'b1, 1'b0, 10'd0, "R8");
        frame(4'd11, 10'd100,  "R8");
        send(5'd0, 4'd0, 4'd0, 10'd0, 1'b1, 1'b0, 10'd0, "R8");
        frame(4'd14, 10'd0,    "R8");
        send(5'd0, 4'd0, 4'd0, 10'd0, 1'b1, 1'b0, 10'd0, "R8");
        send(5'd0, 4'd0, 4'd0, 10'd0, 1'b1, 1'b0, 10'd0, "R8");
        send(5'd24, 4'd14, 4'd0, 10'd0, 1'b0, 1'b0, 10'd0, "R9");
        send(5'd0,  4'd0,  4'd0, 10'd0, 1'b0, 1'b0, 10'd0, "R9");
        send(5'd24, 4'd11, 4'd0, 10'd9, 1'b0, 1'b0, 10'd0, "R9");
        send(5'd24, 4'd10, 4'd0, 10'd0, 1'b0, 1'b0, 10'd0, "R12");
        send(5'd24, 4'd0,  4'd0, 10'd0, 1'b0, 1'b1, 10'd700, "R10");
        send(5'd24, 4'd11, 4'd0, 10'd5, 1'b1, 1'b1, 10'd777, "R10");
        frame(4'd14, 10'd0,    "R11");
        send(5'd23, 4'd11, 4'd0, 10'd9, 1'b1, 1'b0, 10'd0, "R11");
        send(5'd16, 4'd10, 4'd0, 10'd0, 1'b1, 1'b0, 10'd0, "R11");
        send(5'd0,  4'd0,  4'd0, 10'd0, 1'b1, 1'b0, 10'd0, "R11");
        frame(4'd10, 10'd0,    "R12");
        send(5'd24, 4'd11, 4'd3, 10'd42, 1'b1, 1'b0, 10'd0, "R13");
        send(5'd24, 4'd14, 4'd3, 10'd0,  1'b1, 1'b0, 10'd0, "R13");
        send(5'd0,  4'd0,  4'd0, 10'd0,  1'b1, 1'b0, 10'd0, "R13");
        send(5'd24, 4'd13, 4'd3, 10'd0,  1'b1, 1'b0, 10'd0, "R13");
        send(5'd24, 4'd10, 4'd7, 10'd0,  1'b1, 1'b0, 10'd0, "R13");
        frame(4'd0, 10'd3,     "R13");
        frame(4'd2, 10'd3,     "R13");
        frame(4'd8, 10'd3,     "R13");
        frame(4'd3, 10'd3,     "R13");
        idle(4, "R2");
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule